// File: doc/BRIEF.md
# Byte-Wide Counter Snapshot Reader

This block holds a bank of 16-bit event counters and lets an 8-bit host bus read them without tearing a value. Each counter adds one for every pulse on its event input and clears when the host reads it. A counter has two byte addresses, one for the upper byte and one for the lower byte, and the host may read either byte first.

The read that touches a counter byte returns that byte. In the same access, the other byte is copied into one shared holding register at a fixed address. The host's second read always goes to that holding register, so the two halves it gets were taken at the same instant. Reads are strobed, and the data appears on the read bus in the cycle after the strobe.

Top module: `cnt_snap_reader`

## Requirements
- R1: After a synchronous active-high reset, every counter and the holding register are zero, and the read bus shows 0x00.
- R2: Each cycle with an event pulse on a counter's input adds one to that counter, as long as that counter is not being read in that cycle.
- R3: A strobed read of address 0x50+2k returns the upper byte of counter k, and a read of 0x51+2k returns its lower byte. The data appears on the read bus one cycle after the strobe, and the bus shows 0x00 in any cycle that follows no read.
- R4: A read of either byte of a counter copies the other byte of that counter into the holding register. The value copied is the one present before the counter clears.
- R5: A read of either byte clears all 16 bits of that counter.
- R6: An event pulse that arrives in the same cycle as a clearing read is kept, so the counter holds 1 after that read.
- R7: A counter stops at 0xFFFF and stays there under further events until it is read.
- R8: A read of address 0x6C returns the holding register and leaves it unchanged. The holding register changes only when a counter byte is read.
- R9: A read of any unmapped address returns 0x00 and changes no counter and not the holding register.
- R10: A read of one counter leaves every other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | One event pulse per counter, one count per high cycle |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |

## Verification
The hardest case to produce is a counter at its ceiling of 0xFFFF, because that takes 65,535 event cycles. The bench drives a continuous run of more than 65,536 pulses into one counter, then reads it and checks that the result is 0xFF in both bytes rather than a wrapped value. The second hard case is a clearing read that lands in the same cycle as an event. The bench raises the event pulse and the read strobe together in one cycle, then checks that the counter comes back as 1 and that the holding register got the byte from before the clear.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 2 * BYTE_W;
    localparam int ADDR_W    = 8;
    localparam int NUM_CNT   = 4;
    localparam int IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
    localparam logic [ADDR_W-1:0] BASE_ADDR = 8'h50;
    localparam logic [ADDR_W-1:0] HOLD_ADDR = 8'h6C;
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

    typedef struct packed {
        logic             hit_cnt;
        logic             hit_hold;
        logic [IDX_W-1:0] idx;
        logic             low_byte;
    } addr_dec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_split_t;

    function automatic cnt_split_t split_cnt(input logic [CNT_W-1:0] v);
        cnt_split_t s;
        s.hi = v[CNT_W-1:BYTE_W];
        s.lo = v[BYTE_W-1:0];
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] next_count(
        input logic [CNT_W-1:0] cur,
        input logic             evt,
        input logic             clr
    );
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        if (clr)
            return evt ? one : '0;
        else if (evt && cur != CNT_MAX)
            return cur + one;
        else
            return cur;
    endfunction

endpackage

// File: rtl/snap_addr_decode.sv
module snap_addr_decode
    import cnt_snap_pkg::*;
#(
    parameter int N_CNT = NUM_CNT
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_dec_t         dec
);
    localparam int SPAN = 2 * N_CNT;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset       = addr - BASE_ADDR;
        dec.hit_cnt  = (addr >= BASE_ADDR) && (int'(offset) < SPAN);
        dec.hit_hold = (addr == HOLD_ADDR);
        dec.idx      = offset[IDX_W:1];
        dec.low_byte = offset[0];
    end

endmodule

// File: rtl/snap_event_counter.sv
module snap_event_counter
    import cnt_snap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= next_count(cnt, evt, clr);
    end

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> (cnt == '0));

    // R6
    clr_keep_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && evt) |=> (cnt == CNT_W'(1)));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R2
    incr_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && evt && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/snap_hold_reg.sv
module snap_hold_reg
    import cnt_snap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (load)
            hold <= din;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold));

endmodule

// File: rtl/cnt_snap_reader.sv
module cnt_snap_reader
    import cnt_snap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] evt_pulse,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data
);
    addr_dec_t         dec;
    logic [CNT_W-1:0]  cnt_arr [NUM_CNT];
    logic [NUM_CNT-1:0] clr_vec;
    cnt_split_t        sel;
    logic              cnt_rd;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] other_byte;
    logic [BYTE_W-1:0] rd_next;

    snap_addr_decode #(.N_CNT(NUM_CNT)) dec_i (
        .addr (rd_addr),
        .dec  (dec)
    );

    assign cnt_rd = rd_en && dec.hit_cnt;

    generate
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
            assign clr_vec[k] = cnt_rd && (dec.idx == IDX_W'(k));
            snap_event_counter cnt_i (
                .clk (clk),
                .rst (rst),
                .evt (evt_pulse[k]),
                .clr (clr_vec[k]),
                .cnt (cnt_arr[k])
            );
        end
    endgenerate

    always_comb begin
        sel        = split_cnt(cnt_arr[dec.idx]);
        other_byte = dec.low_byte ? sel.hi : sel.lo;
        if (!rd_en)
            rd_next = '0;
        else if (dec.hit_cnt)
            rd_next = dec.low_byte ? sel.lo : sel.hi;
        else if (dec.hit_hold)
            rd_next = hold_q;
        else
            rd_next = '0;
    end

    snap_hold_reg hold_i (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_rd),
        .din  (other_byte),
        .hold (hold_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_next;
    end

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.hit_cnt && !dec.hit_hold) |=> (rd_data == '0));

    // R8
    hold_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dec.hit_hold) |=> (rd_data == $past(hold_q) && $stable(hold_q)));

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    // R10
    one_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

endmodule

// File: tb/cnt_snap_reader_tb_top.sv
module cnt_snap_reader_tb_top;
    import cnt_snap_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_CNT-1:0] evt_pulse;
    logic               rd_en;
    logic [ADDR_W-1:0]  rd_addr;
    logic [BYTE_W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cnt_snap_reader dut_i (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // fields: [34:33] counter, [32] low byte first, [31:16] events,
    //         [15:8] expected first byte, [7:0] expected holding byte
    localparam int NV = 6;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'h0123, 8'h01, 8'h23},
        {2'd1, 1'b1, 16'h0123, 8'h23, 8'h01},
        {2'd2, 1'b0, 16'h02FF, 8'h02, 8'hFF},
        {2'd3, 1'b1, 16'h0005, 8'h05, 8'h00},
        {2'd0, 1'b1, 16'h0100, 8'h00, 8'h01},
        {2'd3, 1'b0, 16'h0000, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            evt_pulse = NUM_CNT'(1) << idx;
            @(posedge clk); #1;
        end
        evt_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_en   = 1'b1;
        rd_addr = a;
        @(posedge clk); #1;
        d     = rd_data;
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] hi_a(input int k);
        return BASE_ADDR + 8'(2 * k);
    endfunction

    initial begin
        logic [7:0] d;
        rst = 1'b1; evt_pulse = '0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        rst = 1'b0;
        @(posedge clk); #1;
        for (int k = 0; k < NUM_CNT; k++) begin
            rd(hi_a(k), d); check("R1 counter", d, 8'h00);
        end
        rd(HOLD_ADDR, d); check("R1 hold", d, 8'h00);

        // R2 R3 R4 R5: table of event counts and byte order
        for (int v = 0; v < NV; v++) begin
            int idx;
            logic [7:0] first_a;
            idx     = int'(VEC[v][34:33]);
            first_a = hi_a(idx) + {7'd0, VEC[v][32]};
            pulse(idx, int'(VEC[v][31:16]));
            rd(first_a, d); check("R2/R3 first byte", d, VEC[v][15:8]);
            @(posedge clk); #1;
            check("R3 idle bus", rd_data, 8'h00);
            rd(HOLD_ADDR, d); check("R4 holding byte", d, VEC[v][7:0]);
            rd(first_a ^ 8'h01, d); check("R5 cleared", d, 8'h00);
        end

        // R6: event in the same cycle as the clearing read
        pulse(0, 3);
        evt_pulse = 4'b0001;
        rd(hi_a(0), d);
        evt_pulse = '0;
        check("R6 read value", d, 8'h00);
        rd(HOLD_ADDR, d); check("R6 pre-clear low in hold", d, 8'h03);
        rd(hi_a(0) + 8'd1, d); check("R6 restart at one", d, 8'h01);

        // R8: holding register stays put across its own reads and events
        rd(HOLD_ADDR, d); check("R8 hold", d, 8'h00);
        pulse(2, 7);
        rd(HOLD_ADDR, d); check("R8 hold repeat", d, 8'h00);
        rd(hi_a(2) + 8'd1, d); check("R8 counter read", d, 8'h07);
        rd(HOLD_ADDR, d); check("R8 hold reloaded", d, 8'h00);
        rd(HOLD_ADDR, d); check("R8 hold unchanged", d, 8'h00);

        // R9: unmapped read, no side effects
        pulse(1, 9);
        rd(hi_a(3) + 8'd1, d); check("R9 setup", d, 8'h00);
        rd(HOLD_ADDR, d); check("R9 setup hold", d, 8'h00);
        pulse(3, 2);
        rd(hi_a(3), d); // hold becomes 0x02
        rd(8'h40, d); check("R9 unmapped", d, 8'h00);
        rd(8'h58, d); check("R9 past bank", d, 8'h00);
        rd(HOLD_ADDR, d); check("R9 hold untouched", d, 8'h02);

        // R10: other counter intact after reads of counter 3
        rd(hi_a(1) + 8'd1, d); check("R10 neighbour kept", d, 8'h09);

        // R7: saturation
        pulse(1, 65540);
        rd(hi_a(1), d); check("R7 saturated high", d, 8'hFF);
        rd(HOLD_ADDR, d); check("R7 saturated low", d, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule